// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block turns parallel stereo PCM sample pairs into a one-bit serial stream. The bit clock and the left/right clock come from outside. Both are sampled on the system clock, and the serial output is updated only when a bit-clock falling edge is seen, which is the same edge on which the left/right clock changes. The left/right clock serves as a channel indicator in the left justified, right justified and I2S formats. In the two DSP formats it serves as a frame sync.

Sample pairs come in through a valid/ready handshake and wait in a single holding slot. At each frame start the held pair becomes the active pair. If no pair has arrived, the active pair is sent again and an underrun flag is raised for that frame. The word length and the framing convention are chosen by two select inputs. An unsupported combination silences the output and raises a configuration error.

Top module: `aud_tx_serializer`

## Requirements
- R1: Each word is sent most significant bit first. A word of W bits is taken from bits W-1..0 of its 32-bit sample input, and the bits above W are ignored. The word length code `wlen_sel` maps 0→16, 1→20, 2→24 and 3→32 bits.
- R2: The format code `fmt_sel` maps 0 to left justified, 1 to I2S, 2 to right justified, 3 to DSP with one-bit delay and 4 to DSP without delay. Codes 5 to 7, and right justified with a 32-bit word, raise `cfg_err` and hold `sdata` at 0.
- R3: `sdata` changes only on the system clock edge that follows detection of a bit-clock falling edge. It stays constant while the bit clock is high.
- R4: In left justified mode, `lrclk` high marks the left word and low marks the right word. The MSB is driven on the falling edge where `lrclk` changes.
- R5: In I2S mode, `lrclk` low marks the left word. The MSB is driven one bit clock after the `lrclk` change. When a phase is exactly W bit clocks long, the LSB of the previous word is driven on the next change edge.
- R6: In right justified mode (same polarity as left justified), the LSB is driven on the last bit clock of each phase, and zeros come before the MSB. The phase length is the length of the phase before it.
- R7: In the DSP formats, a rising `lrclk` edge starts a frame and a falling `lrclk` edge has no effect. With no delay the left MSB is driven on the sync edge; with delay it comes one bit clock later. The right word follows the left LSB directly.
- R8: After the LSB of a word, `sdata` is 0 until the next word begins.
- R9: `smp_ready` is high exactly when the holding slot is empty. An accepted pair fills the slot, and `smp_ready` goes low on the next clock.
- R10: At each frame start (left phase start, or sync edge) the held pair becomes active. With no pair held, the previous pair is sent again and `underrun` is 1 for that frame; otherwise `underrun` is 0.
- R11: A pair accepted on the same clock as a frame start is used in that frame. `underrun` stays 0 and the slot stays empty.
- R12: After reset, `sdata` is 0, `smp_ready` is 1, `underrun` is 0 and `cfg_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_sel | input | 3 | Framing format code |
| wlen_sel | input | 2 | Word length code |
| bclk | input | 1 | External bit clock |
| lrclk | input | 1 | External left/right clock or frame sync |
| smp_valid | input | 1 | Sample pair offered |
| smp_left | input | 32 | Left sample, right-aligned |
| smp_right | input | 32 | Right sample, right-aligned |
| smp_ready | output | 1 | Holding slot empty, pair will be taken |
| sdata | output | 1 | Serial data out |
| underrun | output | 1 | Current frame repeats the previous pair |
| cfg_err | output | 1 | Unsupported format/length combination |

## Verification
Two pairs of events can fall on the same clock. First, a pair offered on the handshake can be accepted on the exact clock on which a frame start is detected. The bench raises `smp_valid` so that it lands on the clock that sees the frame's first falling edge. It then expects the new pair to be serialized in that frame, `underrun` to stay low and `smp_ready` to stay high. Second, in the delayed formats with an exactly packed phase, the LSB of the outgoing right word is driven on the same edge that latches the next pair. The sweeps with phase length equal to the word length judge this by requiring that this bit still comes from the old pair.

// File: rtl/aud_tx_pkg.sv
`timescale 1ns/1ps
package aud_tx_pkg;

  localparam int SAMPLE_W = 32;

  typedef enum logic [2:0] {
    FMT_LEFT  = 3'd0,
    FMT_I2S   = 3'd1,
    FMT_RIGHT = 3'd2,
    FMT_DSP_A = 3'd3,
    FMT_DSP_B = 3'd4
  } fmt_e;

  typedef struct packed {
    logic [SAMPLE_W-1:0] left;
    logic [SAMPLE_W-1:0] right;
  } pair_t;

  function automatic logic [5:0] word_bits(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd16;
      2'd1:    return 6'd20;
      2'd2:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/ser_edge_sync.sv
`timescale 1ns/1ps
module ser_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk,
  input  logic lrclk,
  output logic fall,
  output logic lr
);

  logic [STAGES-1:0] b_sh;
  logic [STAGES-1:0] l_sh;

  generate
    if (STAGES == 2) begin : g_two
      always_ff @(posedge clk) begin
        if (rst) begin
          b_sh <= '0;
          l_sh <= '0;
        end else begin
          b_sh <= {b_sh[0], bclk};
          l_sh <= {l_sh[0], lrclk};
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          b_sh <= '0;
          l_sh <= '0;
        end else begin
          b_sh <= {b_sh[STAGES-2:0], bclk};
          l_sh <= {l_sh[STAGES-2:0], lrclk};
        end
      end
    end
  endgenerate

  // newest compared sample sits at STAGES-2, older at STAGES-1
  assign fall = b_sh[STAGES-1] & ~b_sh[STAGES-2];
  assign lr   = l_sh[STAGES-2];

endmodule

// File: rtl/ser_slot_ctr.sv
`timescale 1ns/1ps
module ser_slot_ctr import aud_tx_pkg::*; #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall,
  input  logic          lr,
  input  logic [2:0]    fmt,
  output logic [CW-1:0] cnt_new,
  output logic [CW-1:0] cnt_old,
  output logic          edge_now,
  output logic          frame_start,
  output logic          lr_prev,
  output logic [CW:0]   plen,
  output logic          plen_ok
);

  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt_q;
  logic          lr_prev_q;
  logic [CW:0]   plen_q;
  logic          plen_ok_q;
  logic          is_dsp;
  logic          first_lvl;

  always_comb begin
    is_dsp    = (fmt == FMT_DSP_A) || (fmt == FMT_DSP_B);
    first_lvl = (fmt != FMT_I2S);
    if (is_dsp) edge_now = fall && lr && !lr_prev_q;
    else        edge_now = fall && (lr != lr_prev_q);
    frame_start = edge_now && (is_dsp || (lr == first_lvl));
    if (edge_now)           cnt_new = '0;
    else if (cnt_q == CMAX) cnt_new = CMAX;
    else                    cnt_new = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= CMAX;
      lr_prev_q <= 1'b0;
      plen_q    <= '0;
      plen_ok_q <= 1'b0;
    end else if (fall) begin
      cnt_q     <= cnt_new;
      lr_prev_q <= lr;
      if (edge_now) begin
        plen_q    <= {1'b0, cnt_q} + 1'b1;
        plen_ok_q <= (cnt_q != CMAX);
      end
    end
  end

  assign cnt_old = cnt_q;
  assign lr_prev = lr_prev_q;
  assign plen    = edge_now ? ({1'b0, cnt_q} + 1'b1) : plen_q;
  assign plen_ok = edge_now ? (cnt_q != CMAX) : plen_ok_q;

  // R7: a falling sync edge keeps the DSP frame counting
  a_r7_dsp_sync_fall_ignored: assert property (@(posedge clk) disable iff (rst)
    (fall && is_dsp && !lr && lr_prev_q && cnt_q != CMAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R4: a channel change restarts the slot count in the channel-indicator formats
  a_r4_phase_restart: assert property (@(posedge clk) disable iff (rst)
    (fall && !is_dsp && (lr != lr_prev_q)) |=> (cnt_q == '0));

endmodule

// File: rtl/ser_pair_buf.sv
`timescale 1ns/1ps
module ser_pair_buf import aud_tx_pkg::*; (
  input  logic  clk,
  input  logic  rst,
  input  logic  frame_start,
  input  logic  smp_valid,
  input  pair_t in_pair,
  output logic  smp_ready,
  output pair_t cur_pair,
  output pair_t start_pair,
  output logic  underrun
);

  pair_t hold_q;
  pair_t cur_q;
  logic  full_q;
  logic  under_q;
  logic  acc;
  logic  avail;

  always_comb begin
    acc        = smp_valid && !full_q;
    avail      = full_q || acc;
    start_pair = full_q ? hold_q : (acc ? in_pair : cur_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= '0;
      cur_q   <= '0;
      full_q  <= 1'b0;
      under_q <= 1'b0;
    end else if (frame_start) begin
      cur_q   <= start_pair;
      under_q <= !avail;
      full_q  <= 1'b0;
    end else if (acc) begin
      hold_q <= in_pair;
      full_q <= 1'b1;
    end
  end

  assign smp_ready = !full_q;
  assign cur_pair  = cur_q;
  assign underrun  = under_q;

  a_r9_slot_fills: assert property (@(posedge clk) disable iff (rst)
    (acc && !frame_start) |=> !smp_ready);

  a_r10_underrun_flag: assert property (@(posedge clk) disable iff (rst)
    (frame_start && !full_q && !smp_valid) |=> underrun);

  a_r11_bypass_on_start: assert property (@(posedge clk) disable iff (rst)
    (frame_start && acc) |=> (!underrun && smp_ready));

endmodule

// File: rtl/ser_bit_sel.sv
`timescale 1ns/1ps
module ser_bit_sel import aud_tx_pkg::*; #(
  parameter int CW = 8
) (
  input  logic [2:0]    fmt,
  input  logic [1:0]    wcode,
  input  logic [CW-1:0] cnt_new,
  input  logic [CW-1:0] cnt_old,
  input  logic          edge_now,
  input  logic          frame_start,
  input  logic          lr,
  input  logic          lr_prev,
  input  logic [CW:0]   plen,
  input  logic          plen_ok,
  input  pair_t         cur_pair,
  input  pair_t         start_pair,
  output logic          bit_out,
  output logic          cfg_bad
);

  int                  w;
  int                  g;
  int                  idx;
  logic                left;
  logic                hit;
  logic                delayed;
  logic                tail;
  pair_t               src;
  logic [SAMPLE_W-1:0] word;
  logic [4:0]          pos;

  always_comb begin
    cfg_bad = (fmt > 3'd4) || ((fmt == FMT_RIGHT) && (wcode == 2'd3));
    w       = int'(word_bits(wcode));
    delayed = (fmt == FMT_I2S) || (fmt == FMT_DSP_A);
    tail    = delayed && edge_now;
    // the tail bit belongs to the word that was active before this edge
    src     = (frame_start && !tail) ? start_pair : cur_pair;
    if (tail)         g = int'(cnt_old);
    else if (delayed) g = int'(cnt_new) - 1;
    else              g = int'(cnt_new);
    left = 1'b1;
    idx  = 0;
    hit  = 1'b0;
    case (fmt_e'(fmt))
      FMT_LEFT: begin
        left = lr;
        idx  = g;
        hit  = (g < w);
      end
      FMT_I2S: begin
        left = tail ? !lr_prev : !lr;
        idx  = g;
        hit  = (g < w);
      end
      FMT_RIGHT: begin
        left = lr;
        idx  = g + w - int'(plen);
        hit  = plen_ok && (idx >= 0) && (idx < w);
      end
      FMT_DSP_A, FMT_DSP_B: begin
        if (g < w) begin
          left = 1'b1;
          idx  = g;
          hit  = 1'b1;
        end else if (g < 2 * w) begin
          left = 1'b0;
          idx  = g - w;
          hit  = 1'b1;
        end
      end
      default: hit = 1'b0;
    endcase
    word    = left ? src.left : src.right;
    pos     = hit ? 5'(w - 1 - idx) : 5'd0;
    bit_out = hit && !cfg_bad && word[pos];
  end

endmodule

// File: rtl/aud_tx_serializer.sv
`timescale 1ns/1ps
module aud_tx_serializer import aud_tx_pkg::*; #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          fmt_sel,
  input  logic [1:0]          wlen_sel,
  input  logic                bclk,
  input  logic                lrclk,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  output logic                smp_ready,
  output logic                sdata,
  output logic                underrun,
  output logic                cfg_err
);

  logic          fall;
  logic          lr;
  logic [CNT_W-1:0] cnt_new;
  logic [CNT_W-1:0] cnt_old;
  logic          edge_now;
  logic          frame_start;
  logic          lr_prev;
  logic [CNT_W:0] plen;
  logic          plen_ok;
  pair_t         in_pair;
  pair_t         cur_pair;
  pair_t         start_pair;
  logic          bit_nxt;
  logic          cfg_bad;
  logic          sdata_q;
  logic          cfg_err_q;

  assign in_pair = '{left: smp_left, right: smp_right};

  ser_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .bclk(bclk), .lrclk(lrclk), .fall(fall), .lr(lr)
  );

  ser_slot_ctr #(.CW(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .fall(fall), .lr(lr), .fmt(fmt_sel),
    .cnt_new(cnt_new), .cnt_old(cnt_old), .edge_now(edge_now),
    .frame_start(frame_start), .lr_prev(lr_prev), .plen(plen), .plen_ok(plen_ok)
  );

  ser_pair_buf u_buf (
    .clk(clk), .rst(rst), .frame_start(frame_start), .smp_valid(smp_valid),
    .in_pair(in_pair), .smp_ready(smp_ready), .cur_pair(cur_pair),
    .start_pair(start_pair), .underrun(underrun)
  );

  ser_bit_sel #(.CW(CNT_W)) u_sel (
    .fmt(fmt_sel), .wcode(wlen_sel), .cnt_new(cnt_new), .cnt_old(cnt_old),
    .edge_now(edge_now), .frame_start(frame_start), .lr(lr), .lr_prev(lr_prev),
    .plen(plen), .plen_ok(plen_ok), .cur_pair(cur_pair), .start_pair(start_pair),
    .bit_out(bit_nxt), .cfg_bad(cfg_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sdata_q   <= 1'b0;
      cfg_err_q <= 1'b0;
    end else begin
      cfg_err_q <= cfg_bad;
      if (cfg_bad)   sdata_q <= 1'b0;
      else if (fall) sdata_q <= bit_nxt;
    end
  end

  assign sdata   = sdata_q;
  assign cfg_err = cfg_err_q;

  a_r3_data_on_fall_only: assert property (@(posedge clk) disable iff (rst)
    (!fall && !cfg_bad) |=> $stable(sdata));

  a_r2_bad_cfg_quiet: assert property (@(posedge clk) disable iff (rst)
    cfg_bad |=> (!sdata && cfg_err));

endmodule

// File: tb/tb_aud_tx_serializer.sv
`timescale 1ns/1ps
module tb_aud_tx_serializer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  fmt_sel = 3'd0;
  logic [1:0]  wlen_sel = 2'd0;
  logic        bclk = 1'b1;
  logic        lrclk = 1'b0;
  logic        smp_valid = 1'b0;
  logic [31:0] smp_left = '0;
  logic [31:0] smp_right = '0;
  logic        smp_ready;
  logic        sdata;
  logic        underrun;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  aud_tx_serializer dut (
    .clk(clk), .rst(rst), .fmt_sel(fmt_sel), .wlen_sel(wlen_sel),
    .bclk(bclk), .lrclk(lrclk), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_right(smp_right), .smp_ready(smp_ready), .sdata(sdata),
    .underrun(underrun), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  function automatic int wbits(input int wl);
    return (wl == 3) ? 32 : 16 + 4 * wl;
  endfunction

  // undelayed bit for slot s of a frame of 2p bit clocks
  function automatic logic ubit(input int f, input int w, input int p,
                                input logic [31:0] l, input logic [31:0] r, input int s);
    int k;
    logic [31:0] wd;
    k  = s % p;
    wd = (s >= p) ? r : l;
    case (f)
      0, 1: return (k < w) ? wd[w-1-k] : 1'b0;
      2:    return (k >= p - w) ? wd[w-1-(k-(p-w))] : 1'b0;
      3, 4: begin
        if (s < w)          return l[w-1-s];
        else if (s < 2 * w) return r[2*w-1-s];
        else                return 1'b0;
      end
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic lrv(input int f, input int p, input int s);
    if (f == 1)           return (s >= p);
    else if (f == 3 || f == 4) return (s == 0);
    else                  return (s < p);
  endfunction

  // one bit clock: fall, optional push, sample twice, rise
  task automatic tick(input logic lr, input bit push, input bit at_start,
                      input logic [31:0] pl, input logic [31:0] pr, output logic got);
    logic early;
    @(negedge clk);
    bclk  = 1'b0;
    lrclk = lr;
    @(negedge clk);
    if (push) begin
      chk("R9", "ready before push", smp_ready, 1'b1);
      smp_valid = 1'b1;
      smp_left  = pl;
      smp_right = pr;
    end
    @(negedge clk);
    smp_valid = 1'b0;
    if (push) chk(at_start ? "R11" : "R9", "ready after push", smp_ready, at_start);
    early = sdata;
    @(negedge clk);
    got = sdata;
    chk("R3", "stable within bit", got, early);
    bclk = 1'b1;
  endtask

  task automatic do_reset(input int f, input int wl);
    rst       = 1'b1;
    bclk      = 1'b1;
    lrclk     = 1'b0;
    smp_valid = 1'b0;
    fmt_sel   = 3'(f);
    wlen_sel  = 2'(wl);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_cfg(input int f, input int wl, input int p, input bit collide);
    int w;
    bit bad;
    bit delayed;
    logic [31:0] a_l, a_r, b_l, b_r, c_l, c_r, fl, fr_r, pl, pr;
    logic u, e, got, prev_u;
    bit push, at_start;
    string tag;
    w       = wbits(wl);
    bad     = (f > 4) || (f == 2 && wl == 3);
    delayed = (f == 1) || (f == 3);
    a_l = 32'h9E3779B9 * 32'(f * 8 + wl + 1) + 32'(p);
    a_r = {a_l[15:0], a_l[31:16]} ^ 32'h3C3CC3C3;
    b_l = ~a_l ^ 32'h5A5A1234;
    b_r = {a_r[7:0], a_r[31:8]} ^ 32'h0F0F00FF;
    c_l = a_l ^ 32'hFFFF0000;
    c_r = b_r ^ 32'h00FFFF00;
    tag = bad ? "R2" : (f == 0) ? "R1/R4" : (f == 1) ? "R5" : (f == 2) ? "R6" : "R7";
    do_reset(f, wl);
    prev_u = 1'b0;
    for (int fr = -1; fr <= 2; fr++) begin
      if (fr < 0)       begin fl = '0;  fr_r = '0;  end
      else if (fr == 0) begin fl = a_l; fr_r = a_r; end
      else if (fr == 1 || !collide) begin fl = b_l; fr_r = b_r; end
      else              begin fl = c_l; fr_r = c_r; end
      for (int s = 0; s < 2 * p; s++) begin
        push = 1'b0; at_start = 1'b0; pl = '0; pr = '0;
        if (fr == -1 && s == p) begin push = 1'b1; pl = a_l; pr = a_r; end
        if (fr == 0 && s == p)  begin push = 1'b1; pl = b_l; pr = b_r; end
        if (fr == 2 && s == 0 && collide) begin
          push = 1'b1; at_start = 1'b1; pl = c_l; pr = c_r;
        end
        tick(lrv(f, p, s), push, at_start, pl, pr, got);
        u      = bad ? 1'b0 : ubit(f, w, p, fl, fr_r, s);
        e      = delayed ? prev_u : u;
        prev_u = u;
        if (fr >= 0) begin
          if (e == 1'b0 && !bad) chk("R8", "zero or data bit", got, e);
          else                   chk(tag, "serial bit", got, e);
          if (s == 0) begin
            chk((fr == 2 && collide) ? "R11" : "R10", "underrun flag",
                underrun, (fr == 2 && !collide));
            chk("R2", "config error flag", cfg_err, bad);
          end
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset(0, 0);
    chk("R12", "sdata after reset", sdata, 1'b0);
    chk("R12", "ready after reset", smp_ready, 1'b1);
    chk("R12", "underrun after reset", underrun, 1'b0);
    chk("R12", "cfg_err after reset", cfg_err, 1'b0);
    for (int f = 0; f < 5; f++)
      for (int wl = 0; wl < 4; wl++)
        for (int extra = 0; extra <= 2; extra += 2)
          run_cfg(f, wl, wbits(wl) + extra, 1'b0);
    run_cfg(5, 1, 20, 1'b0);
    run_cfg(0, 0, 16, 1'b1);
    run_cfg(3, 0, 16, 1'b1);
    run_cfg(1, 2, 24, 1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule